// File: doc/BRIEF.md
# Interval Timer with Feed-Reload Down Counter

This block is a watchdog-style interval timer running in its non-resetting timer mode. The watchdog clock first passes through a fixed divide-by-32 stage and then through a selectable power-of-two prescaler. The prescaler output decrements an 8-bit down counter. When the counter passes zero it reloads from a software-written reload register, raises a sticky overflow flag and keeps counting. An interrupt request follows the flag while an external enable is high.

Software reaches the block through a simple write port on the watchdog clock. The port has four addresses: reload, control, first feed and second feed. The control register is not used directly. A shadow copy, taken one watchdog clock after the write, drives the counting logic. A feed is the byte 0xA5 written to the first feed address followed by 0x5A written to the second. A feed reloads the counter and restarts the prescaler. A malformed feed is dropped and has no other effect.

Top module: `wdt_timer`

## Requirements
- R1: After reset, count_o is 0xFF, ovf_o is 0 and irq_o is 0. The reload register resets to 0xFF and the control register resets to 0, so counting is stopped.
- R2: A control write to address 1 uses bits [2:0] as the prescaler select n and bit 3 as run. These bits reach the counting logic one clock later. With n=0, a write that sets run produces the first decrement 33 clocks after the write edge.
- R3: While running, the counter decrements once every 32·2^n clocks, for n = 0 to 7.
- R4: When a decrement is due and the count is 0, the counter loads the reload value (address 0) and sets ovf_o in the same clock. Counting then continues.
- R5: ovf_o is cleared only by a control write with bit 4 = 0. A control write with bit 4 = 1 leaves the flag unchanged. If an underflow and a clearing write occur in the same clock, the flag stays set.
- R6: irq_o is high exactly when ovf_o and irq_en are both high.
- R7: Writing 0xA5 to address 2 and then, as the very next write, 0x5A to address 3 is an accepted feed. An accepted feed loads the reload value into the counter and restarts the prescaler, so the next decrement comes 32·2^n clocks after the feed edge. A feed works whether or not run is set.
- R8: A feed is ignored in any of these cases: another write comes between the two feed bytes, the first byte is wrong, or 0x5A arrives with no preceding 0xA5. An ignored feed leaves the count and flag following normal counting.
- R9: While the shadowed run bit is 0, the counter and prescaler hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 reload, 1 control, 2 feed first, 3 feed second |
| wr_data | input | 8 | Write data |
| irq_en | input | 1 | External interrupt enable |
| count_o | output | 8 | Down counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench first targets the one-clock shadow delay and the prescaler restart after a feed. A design that skipped the shadow stage would decrement a clock early. A design that left the prescaler running after a feed would decrement early after the feed. The bench also aborts feeds with an intervening reload write, a wrong first byte and a lone second byte. A design that accepted any of these would load the new reload value. Finally, the bench tries to set the flag by writing a 1, clears it while the timer is stopped, and measures the period at select values 2 and 7. A design with a wrong shift or a settable flag would fail the per-clock comparison against the model.

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int FIX_DIV_W = 5,
  parameter int SEL_W     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       irq_en,
  output logic [7:0] count_o,
  output logic       ovf_o,
  output logic       irq_o
);
  localparam int PRE_W = FIX_DIV_W + (1 << SEL_W) - 1;

  logic [7:0]       reload_q, cnt_q;
  logic [SEL_W:0]   ctrl_q, sh_q;
  logic [PRE_W-1:0] pre_q;
  logic             ovf_q, armed_q;

  wire wr_rel  = wr_en && wr_addr == 2'd0;
  wire wr_ctl  = wr_en && wr_addr == 2'd1;
  wire feed_ok = wr_en && wr_addr == 2'd3 && wr_data == 8'h5A && armed_q;
  wire sh_run  = sh_q[SEL_W];
  wire [PRE_W-1:0] pre_lim = (PRE_W'(1) << (FIX_DIV_W + 32'(sh_q[SEL_W-1:0]))) - PRE_W'(1);
  wire tick = sh_run && pre_q == pre_lim;
  wire uf   = tick && cnt_q == 8'd0 && !feed_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      reload_q <= 8'hFF;
      ctrl_q   <= '0;
      sh_q     <= '0;
      armed_q  <= 1'b0;
    end else begin
      sh_q <= ctrl_q;
      if (wr_rel) reload_q <= wr_data;
      if (wr_ctl) ctrl_q <= wr_data[SEL_W:0];
      if (wr_en)  armed_q <= wr_addr == 2'd2 && wr_data == 8'hA5;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= 8'hFF;
      pre_q <= '0;
    end else if (feed_ok) begin
      cnt_q <= reload_q;
      pre_q <= '0;
    end else if (sh_run) begin
      if (tick) begin
        pre_q <= '0;
        cnt_q <= uf ? reload_q : cnt_q - 8'd1;
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    ovf_q <= 1'b0;
    else if (uf)                   ovf_q <= 1'b1;
    else if (wr_ctl && !wr_data[4]) ovf_q <= 1'b0;

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
  assign irq_o   = ovf_q & irq_en;
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       irq_en,
  input logic [7:0] count_o,
  input logic       ovf_o,
  input logic       irq_o,
  input logic       sh_run,
  input logic       feed_ok,
  input logic       uf,
  input logic [7:0] reload_q
);
  // R4
  underflow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> ovf_o && count_o == $past(reload_q));
  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> $past(wr_en && wr_addr == 2'd1 && !wr_data[4]));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_o);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ovf_o && irq_en);
  // R7
  feed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> count_o == $past(reload_q));
  // R9
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_run && !feed_ok) |=> $stable(count_o));
endmodule

bind wdt_timer wdt_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .irq_en(irq_en), .count_o(count_o), .ovf_o(ovf_o), .irq_o(irq_o),
  .sh_run(sh_q[3]), .feed_ok(feed_ok), .uf(uf), .reload_q(reload_q)
);

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, irq_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count_o;
  logic ovf_o, irq_o;

  int errors = 0, checks = 0;
  string cur_req = "R1";

  int m_reload = 255, m_cnt = 255, m_ctrl = 0, m_sh = 0, m_pre = 0;
  bit m_ovf = 0, m_armed = 0;

  always #2 clk = ~clk;

  wdt_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                 .wr_data(wr_data), .irq_en(irq_en), .count_o(count_o),
                 .ovf_o(ovf_o), .irq_o(irq_o));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model(bit we, int a, int d);
    int lim;
    bit run, feed, tick, uf;
    lim  = (32 << (m_sh & 7)) - 1;
    run  = (m_sh & 8) != 0;
    feed = we && a == 3 && d == 'h5A && m_armed;
    tick = run && m_pre == lim;
    uf   = !feed && tick && m_cnt == 0;
    if (feed) begin m_cnt = m_reload; m_pre = 0; end
    else if (run) begin
      if (tick) begin m_pre = 0; m_cnt = (m_cnt == 0) ? m_reload : m_cnt - 1; end
      else m_pre++;
    end
    if (uf) m_ovf = 1;
    else if (we && a == 1 && (d & 'h10) == 0) m_ovf = 0;
    m_sh = m_ctrl;
    if (we && a == 1) m_ctrl = d & 'hF;
    if (we && a == 0) m_reload = d;
    if (we) m_armed = (a == 2 && d == 'hA5);
  endtask

  task automatic step(bit we, bit [1:0] a, bit [7:0] d);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(we, a, d);
    #1;
    check({cur_req, " count"}, count_o, m_cnt);
    check({cur_req, " ovf"}, ovf_o, m_ovf);
    check({cur_req, " irq"}, irq_o, m_ovf & irq_en);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  task automatic feed();
    step(1, 2, 8'hA5);
    step(1, 3, 8'h5A);
  endtask

  task automatic measure(int lim, output int cyc);
    int start;
    start = count_o;
    cyc = 0;
    while (count_o == start && cyc < lim) begin idle(1); cyc++; end
  endtask

  task automatic wait_ovf(int lim, output int cyc);
    cyc = 0;
    while (!ovf_o && cyc < lim) begin idle(1); cyc++; end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 count", count_o, 8'hFF);
    check("R1 ovf", ovf_o, 0);
    check("R1 irq", irq_o, 0);
    idle(5);
    check("R1 stopped", count_o, 8'hFF);

    // R7 feed while stopped
    cur_req = "R7";
    step(1, 0, 8'd3);
    feed();
    check("R7 feed load", count_o, 3);

    // R2 shadow delay: first decrement 33 clocks after run write
    cur_req = "R2";
    step(1, 1, 8'h08);
    idle(32);
    check("R2 before", count_o, 3);
    idle(1);
    check("R2 first dec", count_o, 2);

    // R4 underflow and reload; R6 gating
    cur_req = "R4";
    idle(3 * 32);
    check("R4 reload", count_o, 3);
    check("R4 ovf set", ovf_o, 1);
    check("R6 irq gated", irq_o, 0);
    cur_req = "R6";
    @(negedge clk); irq_en = 1'b1;
    idle(1);
    check("R6 irq on", irq_o, 1);

    // R5 writing 1 keeps flag, writing 0 clears it
    cur_req = "R5";
    step(1, 1, 8'h18);
    check("R5 keep", ovf_o, 1);
    step(1, 1, 8'h08);
    check("R5 clear", ovf_o, 0);
    check("R6 irq off", irq_o, 0);

    // R7 prescaler restart on feed
    cur_req = "R7";
    step(1, 0, 8'd5);
    idle(10);
    feed();
    idle(31);
    check("R7 hold after feed", count_o, 5);
    idle(1);
    check("R7 restart", count_o, 4);

    // R8 bad feeds ignored
    cur_req = "R8";
    step(1, 0, 8'h40);
    step(1, 2, 8'hA5);
    step(1, 0, 8'h40);
    step(1, 3, 8'h5A);
    check("R8 aborted", count_o != 8'h40, 1);
    step(1, 2, 8'h11);
    step(1, 3, 8'h5A);
    check("R8 wrong byte", count_o != 8'h40, 1);
    step(1, 3, 8'h5A);
    check("R8 lone second", count_o != 8'h40, 1);
    idle(5);

    // R3 period at select 2
    cur_req = "R3";
    step(1, 1, 8'h0A);
    measure(2000, c);
    measure(2000, c);
    check("R3 sel2 period", c, 128);

    // R3 period at select 7 with reload 0
    step(1, 0, 8'h00);
    step(1, 1, 8'h0F);
    feed();
    step(1, 1, 8'h0F);
    wait_ovf(10000, c);
    check("R3 sel7 first ovf", ovf_o, 1);
    step(1, 1, 8'h0F);
    wait_ovf(10000, c);
    check("R3 sel7 period", c + 1, 4096);

    // R9 run clear holds state
    cur_req = "R9";
    step(1, 0, 8'd9);
    step(1, 1, 8'h07);
    feed();
    idle(300);
    check("R9 hold", count_o, 9);
    step(1, 1, 8'h08);
    idle(34);
    check("R9 resume", count_o, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule